// File: doc/BRIEF.md
# Programmable-Duty Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A prescaler counts system cycles and emits a tick every `pre` cycles. A period counter steps on each tick through `n` counts. For the first `n - h` counts of each period the serial clock sits at its idle level, and for the last `h` counts it sits at the opposite level. The output frequency is therefore the system clock divided by `pre * n`, and the duty cycle is set by `h`. A bypass bit skips both counters and passes the system clock straight to the output.

The block also applies clock polarity. It turns the output transitions into registered strobes for the shift engine next to it: one for a physical rising edge, one for a falling edge, and a launch/sample pair whose assignment depends on the mode. The strobes are high in the same cycle that the new registered level first shows on the output. Software works out the divider fields and writes them as one packed configuration word, each count stored as its value minus one. The block takes a new word only at the end of a period, so a reprogrammed divider never produces a runt pulse.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rstN` is low, `sclk`, `riseStb`, `fallStb`, `launchStb` and `sampleStb` are all 0.
- R2: The configuration word is laid out as follows: bit 0 bypass, bit 1 polarity, bit 2 phase, bits 8:3 high count minus one, bits 14:9 period count minus one, bits 27:15 prescale minus one. With bypass clear and enable high, `sclk` repeats every `pre * n` system cycles, giving one rising and one falling edge per period.
- R3: Each period starts with `(n - h) * pre` cycles at the idle level, followed by `h * pre` cycles at the opposite level.
- R4: A period field of 0 is treated as `n = 2`. A high count `h >= n` is treated as `h = n - 1`, so every period has at least one idle and one active count.
- R5: While `enable` is low, both counters are cleared, `sclk` shows the polarity bit of the current word (0 means idle low), and no strobe is raised. After `enable` rises, `sclk` first leaves idle at the `((n - h) * pre)`-th rising clock edge that samples `enable` high.
- R6: While bypass is in effect, `sclk` equals the system clock (inverted when polarity is 1), all four strobes are held at 1, and the divider fields have no effect.
- R7: In divider mode, `riseStb` (or `fallStb`) is 1 for exactly the one cycle in which `sclk` first shows its new high (or low) level. The two are never 1 together.
- R8: When polarity equals phase, `launchStb` follows the falling-edge strobe and `sampleStb` the rising one. Otherwise `launchStb` follows the rising-edge strobe and `sampleStb` the falling one.
- R9: While enabled in divider mode, a new configuration word takes effect only at a period wrap, that is, at the end of the last count of a period. Words written in the middle of a period do not change that period. In bypass the reload happens every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider; low clears it and holds idle |
| cfgWord | input | 28 | Packed bypass, polarity, phase, high, period and prescale fields |
| sclk | output | 1 | Serial clock |
| riseStb | output | 1 | Serial clock has just risen |
| fallStb | output | 1 | Serial clock has just fallen |
| launchStb | output | 1 | Shift engine should drive its next bit |
| sampleStb | output | 1 | Shift engine should capture the incoming bit |

## Verification
The end of a period is where two functions coincide. In that cycle the period counter wraps, which produces the falling transition of the last active count, and the new configuration word is taken, which can change polarity, phase, the divider fields or the bypass bit. The bench provokes this by rewriting the word part-way through a period, both to shorter divider settings and to bypass and back. A behavioural model, built on a cycle-in-period integer and not on two counters, predicts on every clock which period the old word still governs, where the new one starts, and which strobe the wrap edge must raise.

// File: rtl/spi_sclk_gen_pkg.sv
package spi_sclk_gen_pkg;

  // Per-cycle request from the control half to the output datapath.
  typedef struct packed {
    logic active;      // enable is high this cycle
    logic byp;         // bypass is in effect this cycle
    logic bypPol;      // polarity to apply to the passed-through clock
    logic level;       // physical serial clock level after this edge
    logic fallLaunch;  // launch on falling edge, sample on rising edge
  } clkStb_t;

endpackage

// File: rtl/spi_sclk_gen_ctrl.sv
module spi_sclk_gen_ctrl #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6,
  parameter int CFG_W = 3 + 2 * CNT_W + PRE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [CFG_W-1:0]          cfgWord,
  output spi_sclk_gen_pkg::clkStb_t stb
);
  localparam int BYP_BIT = 0;
  localparam int POL_BIT = 1;
  localparam int PHA_BIT = 2;
  localparam int H_LSB   = 3;
  localparam int N_LSB   = H_LSB + CNT_W;
  localparam int PRE_LSB = N_LSB + CNT_W;

  // Raw fields of the incoming word
  logic [PRE_W-1:0] inPre;
  logic [CNT_W-1:0] inN, inH, effN, effH;
  logic             inByp, inPol, inPha;

  assign inByp = cfgWord[BYP_BIT];
  assign inPol = cfgWord[POL_BIT];
  assign inPha = cfgWord[PHA_BIT];
  assign inH   = cfgWord[H_LSB +: CNT_W];
  assign inN   = cfgWord[N_LSB +: CNT_W];
  assign inPre = cfgWord[PRE_LSB +: PRE_W];

  // Normalise: period of at least two counts, at least one idle count
  always_comb begin
    effN = (inN == '0) ? CNT_W'(1) : inN;
    effH = (inH >= effN) ? effN : inH + CNT_W'(1);
  end

  // Active configuration, reloaded only at load points
  logic [PRE_W-1:0] actPre;
  logic [CNT_W-1:0] actN;   // n - 1
  logic [CNT_W-1:0] actH;   // h (not minus one)
  logic             actByp, actPol, actPha;

  logic [PRE_W-1:0] preCnt, preNext;
  logic [CNT_W-1:0] perCnt, perNext;
  logic [CNT_W:0]   lowCnt;
  logic             tick, wrap, run, load, rawNext, polNext, phaNext;

  assign run    = enable && !actByp;
  assign tick   = (preCnt == actPre);
  assign wrap   = run && tick && (perCnt == actN);
  assign load   = !enable || actByp || wrap;
  assign lowCnt = {1'b0, actN} + (CNT_W+1)'(1) - {1'b0, actH};

  always_comb begin
    if (!run) begin
      preNext = '0;
      perNext = '0;
    end else if (tick) begin
      preNext = '0;
      perNext = (perCnt == actN) ? '0 : perCnt + CNT_W'(1);
    end else begin
      preNext = preCnt + PRE_W'(1);
      perNext = perCnt;
    end
  end

  assign rawNext = run && ({1'b0, perNext} >= lowCnt);
  assign polNext = load ? inPol : actPol;
  assign phaNext = load ? inPha : actPha;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
      actPre <= '0;
      actN   <= CNT_W'(1);
      actH   <= CNT_W'(1);
      actByp <= 1'b0;
      actPol <= 1'b0;
      actPha <= 1'b0;
    end else begin
      preCnt <= preNext;
      perCnt <= perNext;
      if (load) begin
        actPre <= inPre;
        actN   <= effN;
        actH   <= effH;
        actByp <= inByp;
        actPol <= inPol;
        actPha <= inPha;
      end
    end
  end

  always_comb begin
    stb.active     = enable;
    stb.byp        = enable && actByp;
    stb.bypPol     = actPol;
    stb.level      = polNext ^ rawNext;
    stb.fallLaunch = (polNext == phaNext);
  end

  // Counters never leave their programmed range
  assert_per_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    perCnt <= actN);
  assert_pre_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= actPre);
  // Normalised high count leaves at least one idle and one active count
  assert_high_bounds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (actH >= CNT_W'(1)) && (actH <= actN));
  // Disabled: both counters cleared on the next cycle
  assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (perCnt == '0) && (preCnt == '0));
  // Mid-period: active divider fields hold
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !actByp && !wrap) |=> $stable(actN) && $stable(actH) && $stable(actPre));

endmodule

// File: rtl/spi_sclk_gen_dp.sv
module spi_sclk_gen_dp (
  input  logic                      clk,
  input  logic                      rstN,
  input  spi_sclk_gen_pkg::clkStb_t stb,
  output logic                      sclk,
  output logic                      riseStb,
  output logic                      fallStb,
  output logic                      launchStb,
  output logic                      sampleStb
);
  logic sclkQ, bypQ, bypPolQ;
  logic riseQ, fallQ, launchQ, sampleQ;
  logic riseNow, fallNow;

  assign riseNow = stb.active && !sclkQ && stb.level;
  assign fallNow = stb.active && sclkQ && !stb.level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      bypQ    <= 1'b0;
      bypPolQ <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
      launchQ <= 1'b0;
      sampleQ <= 1'b0;
    end else if (stb.byp) begin
      sclkQ   <= stb.level;
      bypQ    <= 1'b1;
      bypPolQ <= stb.bypPol;
      riseQ   <= 1'b1;
      fallQ   <= 1'b1;
      launchQ <= 1'b1;
      sampleQ <= 1'b1;
    end else begin
      sclkQ   <= stb.level;
      bypQ    <= 1'b0;
      riseQ   <= riseNow;
      fallQ   <= fallNow;
      launchQ <= stb.fallLaunch ? fallNow : riseNow;
      sampleQ <= stb.fallLaunch ? riseNow : fallNow;
    end
  end

  assign sclk      = bypQ ? (clk ^ bypPolQ) : sclkQ;
  assign riseStb   = riseQ;
  assign fallStb   = fallQ;
  assign launchStb = launchQ;
  assign sampleStb = sampleQ;

  // Divider mode: at most one edge strobe per cycle
  assert_edge_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bypQ |-> $onehot0({riseQ, fallQ}));
  // A rising strobe comes with a high level, a falling one with a low level
  assert_edge_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bypQ && (riseQ || fallQ)) |-> (sclkQ == riseQ));
  // Every edge is either launch or sample, never both
  assert_role_split_R8: assert property (@(posedge clk) disable iff (!rstN)
    !bypQ |-> (((launchQ || sampleQ) == (riseQ || fallQ)) && !(launchQ && sampleQ)));
  // Disabled: no strobes and no passthrough next cycle
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |=> !riseQ && !fallQ && !launchQ && !sampleQ && !bypQ);
  // Passthrough: all strobes high
  assert_byp_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    bypQ |-> riseQ && fallQ && launchQ && sampleQ);

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6,
  localparam int CFG_W = 3 + 2 * CNT_W + PRE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb,
  output logic             launchStb,
  output logic             sampleStb
);
  spi_sclk_gen_pkg::clkStb_t stb;

  spi_sclk_gen_ctrl #(
    .PRE_W(PRE_W),
    .CNT_W(CNT_W),
    .CFG_W(CFG_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .cfgWord (cfgWord),
    .stb     (stb)
  );

  spi_sclk_gen_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sclk      (sclk),
    .riseStb   (riseStb),
    .fallStb   (fallStb),
    .launchStb (launchStb),
    .sampleStb (sampleStb)
  );

endmodule

// File: tb/spi_sclk_gen_test.sv
`timescale 1ns/100ps
module spi_sclk_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [27:0] cfgWord = '0;
  logic        sclk, riseStb, fallStb, launchStb, sampleStb;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string curReq  = "R1";

  spi_sclk_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb),
    .launchStb(launchStb), .sampleStb(sampleStb)
  );

  always #2.5 clk = ~clk;

  function automatic logic [27:0] fields(bit byp, bit pol, bit pha,
                                         int preF, int nF, int hF);
    return {13'(preF), 6'(nF), 6'(hF), pha, pol, byp};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int mPre, mN, mH, k;
  bit mPol, mPha, mByp;
  bit eLvl, eRise, eFall, eLaunch, eSample, eByp, eBypPol;

  task automatic takeCfg(logic [27:0] w);
    int nF, hF;
    mByp = w[0]; mPol = w[1]; mPha = w[2];
    hF = int'(w[8:3]); nF = int'(w[14:9]);
    mPre = int'(w[27:15]) + 1;
    mN = (nF == 0) ? 2 : nF + 1;
    mH = (hF + 1 >= mN) ? mN - 1 : hF + 1;
  endtask

  always @(posedge clk) begin
    bit nl, raw;
    if (!rstN) begin
      k = 0; mPre = 1; mN = 2; mH = 1; mPol = 0; mPha = 0; mByp = 0;
      eLvl = 0; eRise = 0; eFall = 0; eLaunch = 0; eSample = 0; eByp = 0; eBypPol = 0;
    end else if (!enable) begin
      k = 0; takeCfg(cfgWord);
      eByp = 0; eLvl = mPol;
      eRise = 0; eFall = 0; eLaunch = 0; eSample = 0;
    end else if (mByp) begin
      eBypPol = mPol; takeCfg(cfgWord); k = 0;
      eByp = 1; eLvl = mPol;
      eRise = 1; eFall = 1; eLaunch = 1; eSample = 1;
    end else begin
      k++;
      if (k == mPre * mN) begin
        k = 0; takeCfg(cfgWord);
      end
      raw = (k / mPre) >= (mN - mH);
      nl = mPol ^ raw;
      eRise = !eLvl && nl;
      eFall = eLvl && !nl;
      eLaunch = (mPol == mPha) ? eFall : eRise;
      eSample = (mPol == mPha) ? eRise : eFall;
      eByp = 0; eLvl = nl;
    end
    #1;
    if (!done) begin
      logic [4:0] act, exp;
      act = {sclk, riseStb, fallStb, launchStb, sampleStb};
      exp = {eByp ? ~eBypPol : eLvl, eRise, eFall, eLaunch, eSample};
      check(act == exp, curReq, "{sclk,rise,fall,launch,sample}", int'(act), int'(exp));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt;
    // R1: reset state
    cyc(3);
    @(posedge clk); #1;
    check({sclk, riseStb, fallStb, launchStb, sampleStb} == 5'b0, "R1",
          "outputs in reset", int'({sclk, riseStb, fallStb, launchStb, sampleStb}), 0);
    @(negedge clk); rstN = 1;

    // R2: pre 1, n 4, h 2
    curReq = "R2";
    cfgWord = fields(0, 0, 0, 0, 3, 1); enable = 1;
    cyc(40);
    // R2: pre 3, n 5, h 1, polarity 1: 10 rises in 150 cycles
    enable = 0; cfgWord = fields(0, 1, 1, 2, 4, 0); cyc(2);
    enable = 1; cyc(20);
    cnt = 0;
    for (int i = 0; i < 150; i++) begin @(posedge clk); #1; cnt += riseStb; end
    check(cnt == 10, "R2", "rises in 150 cycles", cnt, 10);

    // R3: pre 2, n 5, h 4: 80 active cycles in 100
    @(negedge clk); curReq = "R3";
    enable = 0; cfgWord = fields(0, 0, 0, 1, 4, 3); cyc(2);
    enable = 1; cyc(20);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(posedge clk); #1; cnt += sclk; end
    check(cnt == 80, "R3", "high cycles in 100", cnt, 80);

    // R8: polarity 0, phase 1
    @(negedge clk); curReq = "R8";
    enable = 0; cfgWord = fields(0, 0, 1, 1, 3, 1); cyc(2);
    enable = 1; cyc(60);

    // R4: period field 0 -> n 2, h 1, toggles every cycle
    curReq = "R4";
    enable = 0; cfgWord = fields(0, 0, 0, 0, 0, 5); cyc(2);
    enable = 1; cyc(10);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(posedge clk); #1; cnt += riseStb; end
    check(cnt == 20, "R4", "rises in 40 cycles with n field 0", cnt, 20);
    @(negedge clk);
    enable = 0; cfgWord = fields(0, 0, 0, 0, 3, 7); cyc(2);
    enable = 1; cyc(40);

    // R5: idle follows polarity, first edge latency
    curReq = "R5";
    enable = 0; cfgWord = fields(0, 1, 0, 0, 3, 1); cyc(3);
    #1;
    check(sclk == 1 && !riseStb && !fallStb, "R5", "idle with polarity 1",
          int'({sclk, riseStb, fallStb}), 4);
    @(negedge clk); cfgWord = fields(0, 0, 0, 1, 3, 0); cyc(3);
    enable = 1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1; cnt++;
      if (sclk) break;
    end
    check(cnt == 6, "R5", "edges to first active level", cnt, 6);
    @(negedge clk); cyc(30);

    // R9: rewrite the word mid-period
    curReq = "R9";
    enable = 0; cfgWord = fields(0, 0, 0, 1, 5, 2); cyc(2);
    enable = 1; cyc(17);
    cfgWord = fields(0, 1, 0, 0, 1, 0); cyc(40);
    cfgWord = fields(0, 0, 1, 2, 2, 0); cyc(5);
    cfgWord = fields(0, 1, 1, 0, 3, 2); cyc(60);

    // R6: bypass entered from a running divider
    curReq = "R6";
    cfgWord = fields(1, 0, 0, 5, 9, 3); cyc(30);
    @(posedge clk); #1;
    check(sclk == 1 && launchStb && sampleStb, "R6", "bypass clk high half",
          int'({sclk, launchStb, sampleStb}), 7);
    @(negedge clk); #1;
    check(sclk == 0, "R6", "bypass clk low half", int'(sclk), 0);
    cyc(1);
    cfgWord = fields(1, 1, 0, 0, 1, 0); cyc(10);
    @(negedge clk); #1;
    check(sclk == 1, "R6", "inverted bypass clk low half", int'(sclk), 1);
    cyc(1);
    cfgWord = fields(0, 0, 0, 0, 3, 1); cyc(40);

    // R7: short period edge strobes
    curReq = "R7";
    cfgWord = fields(0, 0, 0, 0, 2, 0); cyc(30);
    cfgWord = fields(0, 1, 0, 0, 2, 1); cyc(30);

    // R2: large prescale
    curReq = "R2";
    cfgWord = fields(0, 0, 0, 99, 3, 1); cyc(1000);
    enable = 0; cyc(3);
    finishRun();
  end
endmodule